// File: doc/BRIEF.md
# Brown-Out Detector Control Wrapper

This block is the digital side of a supply-monitor comparator. The analog comparator sits outside the block and drives one input bit. That bit is high when the supply is below the selected threshold. The block holds an 8-bit control/status register with these fields:

- a detector enable
- a two-bit threshold select
- a mode bit that picks reset or interrupt
- a low-power bit
- a low-voltage-reset enable

All of these fields are write-protected. A single protect input from the system blocks writes to them.

The comparator output passes through a synchronizer. The block shows it as a status bit, which is forced to 0 while the detector is off. Any change of the synchronized output while the detector is enabled sets a sticky flag. Software clears the flag by writing 1 to it. In reset mode, a low supply drives a chip reset request. In interrupt mode, the flag drives an interrupt line. The threshold and low-power fields only pass on to the analog side; this block stores them and reads them back.

Top module: `bod_ctrl`

## Requirements
- R1: The register layout is: bit 0 enable, bits 2:1 threshold select, bit 3 mode (1 = reset, 0 = interrupt), bit 4 event flag, bit 5 low-power, bit 6 status, bit 7 low-voltage-reset enable. With `prot_en` low, a write stores bits 0, 1, 2, 3, 5 and 7 and reads them back the cycle after.
- R2: With `prot_en` high, a write leaves bits 0, 1, 2, 3, 5 and 7 unchanged. Writing 1 to bit 4 still clears the flag.
- R3: Status (bit 6) reads 0 while the enable is 0. Otherwise it equals the synchronized comparator value.
- R4: While enabled, a rise or a fall of the synchronized comparator sets the flag. The flag holds until a write with bit 4 = 1 clears it.
- R5: `rst_req` is high exactly when enable = 1, mode = 1 and status = 1.
- R6: `irq` is high exactly when enable = 1, mode = 0 and the flag is set. Clearing the enable drops `irq` on the next cycle, even if the flag stays set.
- R7: After reset the register reads 0x80: low-voltage-reset enable is 1 and every other field is 0.
- R8: A change on `cmp_in` reaches status after two clock edges and sets the flag on the third. Turning the enable on while the comparator is already high sets no flag.
- R9: A write with bit 4 = 0 leaves the flag as it is. A flag-setting change in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| prot_en | input | 1 | 1 = protected fields locked |
| cmp_in | input | 1 | Raw comparator output, 1 = supply below threshold |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Chip reset request |

## Verification
Every state bit of this block is visible in `rd_data`. A wrong configuration bit, flag or synchronizer value therefore shows at the ports within one to three edges of the stimulus that caused it. A stuck or mis-gated flag shows in bit 4 and in `irq`. A synchronizer that is off by one stage moves the status and flag changes by a cycle, and the bench samples those changes in their exact cycle. Any leak through the write protection shows as a changed read-back on the cycle after the locked write.

// File: rtl/bod_pkg.sv
// Package: shared field positions and the configuration record of the
// brown-out control wrapper. Assumes an 8-bit register view.
package bod_pkg;
    localparam int REG_W     = 8;
    localparam int VSEL_W    = 2;
    localparam int B_EN      = 0;
    localparam int B_VSEL_LO = 1;
    localparam int B_RMODE   = 3;
    localparam int B_FLAG    = 4;
    localparam int B_LPM     = 5;
    localparam int B_STAT    = 6;
    localparam int B_LVR     = 7;

    typedef struct packed {
        logic              lvr_en;
        logic              lpm;
        logic              rmode;
        logic [VSEL_W-1:0] vsel;
        logic              en;
    } bod_cfg_t;
endpackage

// File: rtl/bod_sync.sv
// Module: multi-flop synchronizer for the asynchronous comparator output.
// Assumes STAGES >= 2. Reset value of every stage is 0.
module bod_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/bod_cfg_regs.sv
// Module: protected configuration fields. A write updates them only when the
// protect input is low. Assumes the flag and status bits are handled elsewhere.
module bod_cfg_regs
    import bod_pkg::*;
#(
    parameter logic LVR_DEFAULT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             prot_en,
    output bod_cfg_t         cfg
);
    logic wr_ok;
    assign wr_ok = wr_en && !prot_en;

    // Hold or update the protected fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg.lvr_en <= LVR_DEFAULT;
        end else if (wr_ok) begin
            cfg.en     <= wr_data[B_EN];
            cfg.vsel   <= wr_data[B_VSEL_LO +: VSEL_W];
            cfg.rmode  <= wr_data[B_RMODE];
            cfg.lpm    <= wr_data[B_LPM];
            cfg.lvr_en <= wr_data[B_LVR];
        end
    end
endmodule

// File: rtl/bod_event.sv
// Module: status gating and the sticky event flag.
// The flag sets on any change of the synchronized comparator while the
// detector is enabled. A set event wins over a same-cycle clear.
// Assumes cmp_s is already synchronous to clk.
module bod_event (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_s,
    input  logic clr_req,
    output logic status,
    output logic flag
);
    logic cmp_d;
    logic crossing;

    assign status   = en & cmp_s;
    assign crossing = en & (cmp_s ^ cmp_d);

    // Track the previous synchronized value, including while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_d <= 1'b0;
        else        cmp_d <= cmp_s;
    end

    // Sticky flag: set has priority over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (crossing) flag <= 1'b1;
        else if (clr_req)  flag <= 1'b0;
    end
endmodule

// File: rtl/bod_ctrl.sv
// Module: top of the brown-out control wrapper. It joins the synchronizer,
// the protected configuration and the event logic. It assembles the read
// view and steers an event to a reset request or an interrupt.
// Assumes the register bus is a single 8-bit location with a write strobe.
module bod_ctrl
    import bod_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic LVR_DEFAULT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             prot_en,
    input  logic             cmp_in,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             rst_req
);
    bod_cfg_t cfg;
    logic     cmp_s;
    logic     status;
    logic     flag;
    logic     clr_req;

    assign clr_req = wr_en & wr_data[B_FLAG];

    bod_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_in),
        .dout (cmp_s)
    );

    bod_cfg_regs #(.LVR_DEFAULT(LVR_DEFAULT)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .prot_en(prot_en),
        .cfg    (cfg)
    );

    bod_event u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg.en),
        .cmp_s  (cmp_s),
        .clr_req(clr_req),
        .status (status),
        .flag   (flag)
    );

    // Assemble the register read view.
    always_comb begin
        rd_data                        = '0;
        rd_data[B_EN]                  = cfg.en;
        rd_data[B_VSEL_LO +: VSEL_W]   = cfg.vsel;
        rd_data[B_RMODE]               = cfg.rmode;
        rd_data[B_FLAG]                = flag;
        rd_data[B_LPM]                 = cfg.lpm;
        rd_data[B_STAT]                = status;
        rd_data[B_LVR]                 = cfg.lvr_en;
    end

    // Steer the event to reset or interrupt by mode.
    assign rst_req = cfg.en &  cfg.rmode & status;
    assign irq     = cfg.en & ~cfg.rmode & flag;
endmodule

// File: rtl/bod_ctrl_chk.sv
// Module: port-level property checker for bod_ctrl, bound into every instance.
module bod_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_flag,
    input logic       prot_en,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic       rst_req
);
    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        prot_en |=> ({rd_data[7], rd_data[5], rd_data[3:0]} ==
                     $past({rd_data[7], rd_data[5], rd_data[3:0]}))); // R2

    AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> !rd_data[6]); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !(wr_en && wr_flag)) |=> rd_data[4]); // R4

    AST_RST_REQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rd_data[0] && rd_data[3] && rd_data[6])); // R5

    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[0] && !rd_data[3] && rd_data[4])); // R6

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h80)); // R7
endmodule

bind bod_ctrl bod_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_flag(wr_data[bod_pkg::B_FLAG]),
    .prot_en(prot_en),
    .rd_data(rd_data),
    .irq    (irq),
    .rst_req(rst_req)
);

// File: tb/test_bod_ctrl.sv
`timescale 1ns/100ps
module test_bod_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       prot_en = 1'b1;
    logic       cmp_in = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic       rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       irq;
        logic       rst;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bod_ctrl i_bod_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .prot_en(prot_en),
        .cmp_in (cmp_in),
        .rd_data(rd_data),
        .irq    (irq),
        .rst_req(rst_req)
    );

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rd_data !== e.rd || irq !== e.irq || rst_req !== e.rst) begin
                errors++;
                $display("FAIL %s: rd=%h irq=%b rst=%b expected rd=%h irq=%b rst=%b",
                         e.tag, rd_data, irq, rst_req, e.rd, e.irq, e.rst);
            end
        end
    end

    // Driver: push the state expected after the next edge, then advance.
    task automatic step(input string tag, input logic [7:0] rd,
                        input logic ei, input logic er);
        exp_t e;
        e.tag = tag; e.rd = rd; e.irq = ei; e.rst = er;
        sb.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] d, input string tag,
                      input logic [7:0] rd, input logic ei, input logic er);
        wr_en = 1'b1; wr_data = d;
        step(tag, rd, ei, er);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        @(negedge clk); #1;
        step("R7 reset value", 8'h80, 0, 0);
        rst_n = 1'b1;
        step("R7 after release", 8'h80, 0, 0);
        // R2 locked write
        wr(8'h2F, "R2 protected write ignored", 8'h80, 0, 0);
        prot_en = 1'b0;
        wr(8'hAF, "R1 all config fields", 8'hAF, 0, 0);
        wr(8'h0E, "R1 vsel/mode, lvr off", 8'h0E, 0, 0);
        wr(8'h81, "R1 enable interrupt mode", 8'h81, 0, 0);
        // R8 latency on a rise
        cmp_in = 1'b1;
        step("R8 first sync stage", 8'h81, 0, 0);
        step("R3 status follows comparator", 8'hC1, 0, 0);
        step("R4 rise sets flag, R6 irq", 8'hD1, 1, 0);
        wr(8'h81, "R9 write 0 keeps flag", 8'hD1, 1, 0);
        wr(8'h91, "R4 write 1 clears flag", 8'hC1, 0, 0);
        // fall
        cmp_in = 1'b0;
        step("R8 fall stage 1", 8'hC1, 0, 0);
        step("R3 status drops", 8'h81, 0, 0);
        step("R4 fall sets flag", 8'h91, 1, 0);
        step("R6 irq held", 8'h91, 1, 0);
        wr(8'h80, "R6 disable drops irq, R3 status 0", 8'h90, 0, 0);
        wr(8'h90, "R4 clear while disabled", 8'h80, 0, 0);
        // priority
        wr(8'h81, "R1 re-enable", 8'h81, 0, 0);
        cmp_in = 1'b1;
        step("R8 rise stage 1", 8'h81, 0, 0);
        step("R3 status high", 8'hC1, 0, 0);
        wr(8'h91, "R9 set beats clear", 8'hD1, 1, 0);
        wr(8'h91, "R4 clear afterwards", 8'hC1, 0, 0);
        wr(8'h80, "R3 disabled with comparator high", 8'h80, 0, 0);
        step("R3 stays 0 while disabled", 8'h80, 0, 0);
        wr(8'h89, "R5 reset mode asserts rst_req", 8'hC9, 0, 1);
        step("R8 no flag from enabling", 8'hC9, 0, 1);
        cmp_in = 1'b0;
        step("R5 fall stage 1", 8'hC9, 0, 1);
        step("R5 rst_req drops", 8'h89, 0, 0);
        step("R4 flag in reset mode, R6 no irq", 8'h99, 0, 0);
        prot_en = 1'b1;
        wr(8'h10, "R2 flag clear while locked", 8'h89, 0, 0);
        prot_en = 1'b0;
        wr(8'h3F, "R1 lpm and threshold", 8'h2F, 0, 0);
        @(negedge clk); #1;
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
            $finish;
        end
    end
endmodule